// File: doc/BRIEF.md
# Chip-Select Wait-State Generator

This block sits between a processor's external bus and the outside devices. Every bus address is decoded into one of two active-low device selects. Each external bus cycle is then stretched by a number of wait states. That number depends on which select was hit. The lower select covers a window at the bottom of the address map whose size is programmable. The upper select covers the top half of the map.

The lower select can run in one of two wait modes. In register mode its wait count comes from a 3-bit configuration field. In external mode the count is sampled from the three low data-bus lines while the bus is in phase T4. During that phase the block pulls an active-low strobe, so that outside logic knows when to drive the count onto the data bus. The upper select always takes its count from a 2-bit configuration field. An internal-access input marks cycles that are served on chip. Such cycles assert neither select nor the strobe, and they complete without waits.

Top module: `cs_wait_gen`

## Requirements
- R1: After reset, `ready_o` is high and the configuration byte is zero. This gives the smallest lower window, register mode and zero wait states for both selects.
- R2: The lower select `sel_lo_n` goes low while `bus_valid` is high, `int_acc` is low and the address lies in the window chosen by `cfg_wdata[1:0]`. The windows are: 0 → 0x0000-0x0FFF, 1 → 0x0000-0x1FFF, 2 → 0x0000-0x3FFF, 3 → 0x0000-0x7FFF.
- R3: The upper select `sel_hi_n` goes low for a valid, non-internal address in 0x8000-0xFFFF. The two selects are never low together.
- R4: While `int_acc` is high, both selects and the strobe stay high, and a T4 produces zero wait states.
- R5: `wstrb_n` is low exactly when `t4` is high and the lower select is active.
- R6: When `cfg_wdata[2]` is 1 (external mode), the lower select's wait count is `bus_data_lo` as sampled at the clock edge that ends T4. A value of 7 gives 7 waits and a value of 2 gives 2.
- R7: When `cfg_wdata[2]` is 0, the lower select's wait count is `cfg_wdata[5:3]`.
- R8: The upper select's wait count is `cfg_wdata[7:6]` (0 to 3), whatever is on the data bus.
- R9: After the edge that ends T4, `ready_o` stays low for exactly N clocks, where N is the selected count. Later changes on the data bus or in the configuration do not alter N.
- R10: A valid address that hits neither window asserts no select, and its T4 gives zero waits.
- R11: A `t4` that arrives while `ready_o` is low is ignored. It neither reloads nor extends the wait.
- R12: A configuration write (`cfg_we` high) takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 8 | Configuration byte: [1:0] window, [2] external mode, [5:3] lower wait, [7:6] upper wait |
| bus_addr | input | 16 | Bus address |
| bus_valid | input | 1 | Address is valid this cycle |
| int_acc | input | 1 | Access is served by on-chip resources |
| t4 | input | 1 | Bus is in phase T4 |
| bus_data_lo | input | 3 | Low data-bus lines, read in external mode |
| sel_lo_n | output | 1 | Lower chip select, active low |
| sel_hi_n | output | 1 | Upper chip select, active low |
| wstrb_n | output | 1 | Wait-count strobe, active low during T4 |
| ready_o | output | 1 | Low while wait states are being inserted |

## Verification
Some properties are checked on every cycle:
- internal accesses leave the selects and the strobe quiet and add no wait;
- the two selects are exclusive;
- the strobe appears only inside T4 of a lower-select cycle;
- ready only drops on the edge after an accepted T4;
- no wait exceeds seven cycles, and an upper-select wait never exceeds three.

Other behaviour only the bench scenarios can show:
- the exact wait length chosen by each mode and window boundary;
- that the count is latched so later data-bus changes have no effect;
- that a T4 arriving mid-wait is ignored.

// File: rtl/cswg_pkg.sv
package cswg_pkg;

    // Configuration byte, MSB first: upper wait, lower wait, ext mode, window
    typedef struct packed {
        logic [1:0] wait_hi;
        logic [2:0] wait_lo;
        logic       ext_mode;
        logic [1:0] win_sel;
    } cswg_cfg_t;

    localparam int CFG_W  = $bits(cswg_cfg_t);
    localparam int WCNT_W = 3;

endpackage

// File: rtl/cswg_cfg_reg.sv
module cswg_cfg_reg
    import cswg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [CFG_W-1:0]    wdata,
    output cswg_cfg_t           cfg_o
);

    typedef struct packed {
        cswg_cfg_t cfg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.cfg = cswg_cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;

endmodule

// File: rtl/cswg_decode.sv
module cswg_decode
    import cswg_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BLK_SHIFT = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              valid,
    input  logic              int_acc,
    input  logic              t4,
    input  logic [WCNT_W-1:0] data_lo,
    input  cswg_cfg_t         cfg,
    output logic              sel_lo_n,
    output logic              sel_hi_n,
    output logic              wstrb_n,
    output logic [WCNT_W-1:0] wait_n
);

    localparam int SHIFT_W = $clog2(ADDR_W + 1);

    logic               ext_ok;
    logic               hit_lo;
    logic               hit_hi;
    logic [SHIFT_W-1:0] win_shift;

    always_comb begin
        ext_ok    = valid && !int_acc;
        win_shift = SHIFT_W'(BLK_SHIFT) + SHIFT_W'(cfg.win_sel);
        hit_lo    = ext_ok && ((addr >> win_shift) == '0);
        hit_hi    = ext_ok && addr[ADDR_W-1];

        if (hit_lo) begin
            wait_n = cfg.ext_mode ? data_lo : cfg.wait_lo;
        end else if (hit_hi) begin
            wait_n = WCNT_W'(cfg.wait_hi);
        end else begin
            wait_n = '0;
        end
    end

    assign sel_lo_n = !hit_lo;
    assign sel_hi_n = !hit_hi;
    assign wstrb_n  = !(hit_lo && t4);

endmodule

// File: rtl/cswg_wait_ctr.sv
module cswg_wait_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             t4,
    input  logic [CNT_W-1:0] load_val,
    output logic             ready_o
);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.remain != '0) begin
            st_d.remain = st_q.remain - 1'b1;
        end else if (t4) begin
            st_d.remain = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = (st_q.remain == '0);

endmodule

// File: rtl/cs_wait_gen.sv
module cs_wait_gen
    import cswg_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BLK_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_valid,
    input  logic              int_acc,
    input  logic              t4,
    input  logic [WCNT_W-1:0] bus_data_lo,
    output logic              sel_lo_n,
    output logic              sel_hi_n,
    output logic              wstrb_n,
    output logic              ready_o
);

    cswg_cfg_t         cfg;
    logic [WCNT_W-1:0] wait_sel;

    cswg_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_o (cfg)
    );

    cswg_decode #(
        .ADDR_W    (ADDR_W),
        .BLK_SHIFT (BLK_SHIFT)
    ) u_dec (
        .addr     (bus_addr),
        .valid    (bus_valid),
        .int_acc  (int_acc),
        .t4       (t4),
        .data_lo  (bus_data_lo),
        .cfg      (cfg),
        .sel_lo_n (sel_lo_n),
        .sel_hi_n (sel_hi_n),
        .wstrb_n  (wstrb_n),
        .wait_n   (wait_sel)
    );

    cswg_wait_ctr #(
        .CNT_W (WCNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .t4       (t4),
        .load_val (wait_sel),
        .ready_o  (ready_o)
    );

endmodule

// File: rtl/cs_wait_gen_chk.sv
module cs_wait_gen_chk
    import cswg_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BLK_SHIFT = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_valid,
    input logic              int_acc,
    input logic              t4,
    input logic [WCNT_W-1:0] bus_data_lo,
    input logic              sel_lo_n,
    input logic              sel_hi_n,
    input logic              wstrb_n,
    input logic              ready_o
);

    logic [3:0] low_run_q;
    logic       hi_cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q <= '0;
            hi_cyc_q  <= 1'b0;
        end else begin
            low_run_q <= ready_o ? 4'd0 : low_run_q + 4'd1;
            if (ready_o && t4) begin
                hi_cyc_q <= !sel_hi_n;
            end
        end
    end

    a_r4_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        int_acc |-> (sel_lo_n && sel_hi_n && wstrb_n));

    a_r4_internal_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && t4 && int_acc) |=> ready_o);

    a_r3_selects_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sel_lo_n && !sel_hi_n));

    a_r5_strobe_in_t4: assert property (@(posedge clk) disable iff (!rst_n)
        !wstrb_n |-> (t4 && !sel_lo_n));

    a_r9_drop_after_t4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !t4) |=> ready_o);

    a_r6_max_seven: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (low_run_q <= 4'd6));

    a_r8_upper_max_three: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && hi_cyc_q) |-> (low_run_q <= 4'd2));

endmodule

bind cs_wait_gen cs_wait_gen_chk #(
    .ADDR_W    (ADDR_W),
    .BLK_SHIFT (BLK_SHIFT)
) u_chk (.*);

// File: tb/sim_cs_wait_gen.sv
`timescale 1ns/1ps
module sim_cs_wait_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] bus_addr = '0;
    logic        bus_valid = 1'b0;
    logic        int_acc = 1'b0;
    logic        t4 = 1'b0;
    logic [2:0]  bus_data_lo = '0;
    logic        sel_lo_n, sel_hi_n, wstrb_n, ready_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model state
    bit [7:0] m_cfg = '0;
    int       m_cnt = 0;
    bit       obs_ready;

    always #4 clk = ~clk;

    cs_wait_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .bus_addr(bus_addr), .bus_valid(bus_valid), .int_acc(int_acc), .t4(t4),
        .bus_data_lo(bus_data_lo), .sel_lo_n(sel_lo_n), .sel_hi_n(sel_hi_n),
        .wstrb_n(wstrb_n), .ready_o(ready_o)
    );

    function automatic bit m_hit_lo(bit v, bit [15:0] a, bit ia);
        int lim = 4096 << m_cfg[1:0];
        return v && !ia && (int'(a) < lim);
    endfunction

    function automatic bit m_hit_hi(bit v, bit [15:0] a, bit ia);
        return v && !ia && (int'(a) >= 32768);
    endfunction

    function automatic int m_wait(bit v, bit [15:0] a, bit ia, bit [2:0] d);
        if (m_hit_lo(v, a, ia)) return m_cfg[2] ? int'(d) : int'(m_cfg[5:3]);
        if (m_hit_hi(v, a, ia)) return int'(m_cfg[7:6]);
        return 0;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit v, bit [15:0] a, bit ia, bit t, bit [2:0] d,
                        bit we = 1'b0, bit [7:0] wd = 8'h00);
        @(negedge clk);
        bus_valid = v; bus_addr = a; int_acc = ia; t4 = t; bus_data_lo = d;
        cfg_we = we; cfg_wdata = wd;
        #2;
        check(tag, "sel_lo_n", sel_lo_n, !m_hit_lo(v, a, ia));
        check(tag, "sel_hi_n", sel_hi_n, !m_hit_hi(v, a, ia));
        check(tag, "wstrb_n", wstrb_n, !(t && m_hit_lo(v, a, ia)));
        check(tag, "ready_o", ready_o, m_cnt == 0);
        obs_ready = ready_o;
        @(posedge clk);
        if (m_cnt > 0) m_cnt--;
        else if (t) m_cnt = m_wait(v, a, ia, d);
        if (we) m_cfg = wd;
    endtask

    task automatic set_cfg(bit [7:0] wd);
        step("R12", 1'b0, 16'h0, 1'b0, 1'b0, 3'd0, 1'b1, wd);
    endtask

    // full bus cycle: address phase, T4, waits, idle; count observed waits
    task automatic access(string tag, bit [15:0] a, bit ia, bit [2:0] d, bit [2:0] d_late,
                          int exp_w);
        int k = 0;
        step(tag, 1'b1, a, ia, 1'b0, 3'd0);
        step(tag, 1'b1, a, ia, 1'b1, d);
        for (int i = 0; i < 10; i++) begin
            step(tag, 1'b1, a, ia, 1'b0, d_late);
            if (obs_ready) break;
            k++;
        end
        check(tag, "wait count", k, exp_w);
        step(tag, 1'b0, 16'h0, 1'b0, 1'b0, 3'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #20;
        check("R1", "ready_o in reset", ready_o, 1);
        check("R1", "sel_lo_n in reset", sel_lo_n, 1);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: defaults -> smallest window, zero waits
        access("R1", 16'h0FFF, 1'b0, 3'd5, 3'd5, 0);
        access("R1", 16'h1000, 1'b0, 3'd5, 3'd5, 0);
        access("R1", 16'h8000, 1'b0, 3'd5, 3'd5, 0);

        // window 1, register mode, lower 5, upper 2
        set_cfg({2'd2, 3'd5, 1'b0, 2'd1});
        access("R7", 16'h1FFF, 1'b0, 3'd1, 3'd0, 5);
        access("R10", 16'h2000, 1'b0, 3'd7, 3'd7, 0);
        access("R8", 16'hC000, 1'b0, 3'd7, 3'd7, 2);

        set_cfg({2'd0, 3'd1, 1'b0, 2'd2});
        access("R2", 16'h3FFF, 1'b0, 3'd0, 3'd0, 1);
        access("R2", 16'h4000, 1'b0, 3'd0, 3'd0, 0);

        // window 3, external mode, upper 3
        set_cfg({2'd3, 3'd1, 1'b1, 2'd3});
        access("R2", 16'h7FFF, 1'b0, 3'd4, 3'd4, 4);
        access("R3", 16'h8000, 1'b0, 3'd7, 3'd0, 3);
        access("R6", 16'h0100, 1'b0, 3'd7, 3'd0, 7);
        access("R6", 16'h0100, 1'b0, 3'd2, 3'd7, 2);
        access("R9", 16'h0200, 1'b0, 3'd0, 3'd7, 0);
        access("R8", 16'hF000, 1'b0, 3'd1, 3'd1, 3);

        // R4: internal accesses
        access("R4", 16'h0100, 1'b1, 3'd7, 3'd7, 0);
        access("R4", 16'h9000, 1'b1, 3'd7, 3'd7, 0);

        // R11: second T4 during waits ignored
        step("R11", 1'b1, 16'h0300, 1'b0, 1'b1, 3'd3);
        step("R11", 1'b1, 16'h0300, 1'b0, 1'b1, 3'd7);
        step("R11", 1'b1, 16'h0300, 1'b0, 1'b1, 3'd7);
        step("R11", 1'b1, 16'h0300, 1'b0, 1'b0, 3'd7);
        check("R11", "ready after 3 waits", obs_ready, 0);
        step("R11", 1'b0, 16'h0, 1'b0, 1'b0, 3'd0);
        check("R11", "ready restored", obs_ready, 1);

        // R9: configuration change during waits does not alter N
        set_cfg({2'd0, 3'd4, 1'b0, 2'd0});
        step("R9", 1'b1, 16'h0010, 1'b0, 1'b1, 3'd0);
        set_cfg({2'd0, 3'd0, 1'b0, 2'd0});
        step("R9", 1'b1, 16'h0010, 1'b0, 1'b0, 3'd0);
        step("R9", 1'b1, 16'h0010, 1'b0, 1'b0, 3'd0);
        step("R9", 1'b1, 16'h0010, 1'b0, 1'b0, 3'd0);
        check("R9", "still waiting", obs_ready, 0);
        step("R9", 1'b0, 16'h0, 1'b0, 1'b0, 3'd0);
        check("R9", "done after 4", obs_ready, 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule